// File: doc/BRIEF.md
# Proportional-resonant current regulator

This block closes the current loop of a single-phase grid inverter that feeds a 400 Hz supply. Once per control sample it takes four inputs: an active-current amplitude, a reactive-current amplitude, a pair of orthogonal unit signals locked to the grid voltage, and one sample of the measured grid current. From these it forms a current error. The error drives a proportional path and a resonant path in parallel. The resonant path is a damped resonator with limited gain, centred on the grid frequency. The sum of the two paths is saturated and registered as a modulation command for a downstream pulse-width modulator.

The resonator is a second-order recursive section with two state registers. Its numerator and denominator coefficients, the proportional gain and the measurement scale are run-time inputs. These are normally computed elsewhere by trapezoidal discretisation at the sample rate, with the resonant gain folded into the numerator. Normal operation holds the reactive amplitude at zero so that the inverter supplies no reactive power. A synchronous clear wipes all held state, which models a control restart that loses its history.

Top module: `pr_cur_reg`

## Requirements
- R1: After reset, and in the cycle after a clear, `cmd` reads 0 and `cmd_vld` is low. Both resonator states are then zero, so a following sample with zero error yields a command of 0.
- R2: All data inputs are two's-complement Q2.14 in 16 bits. The error is e = floor((act·cos + rea·sin − k_meas·meas) / 2^14), kept in a 32-bit signed accumulator.
- R3: Gains and coefficients are two's-complement Q4.16 in 20 bits. The command is sat16(floor(k_prop·e / 2^16) + y), where y = sat32(floor(b0·e / 2^16) + s1).
- R4: On each accepted sample the states update as s1 ← sat32(floor(a1·y / 2^16) + s2) and s2 ← sat32(floor(a2·y / 2^16) − floor(b0·e / 2^16)). This gives y[n] = b0(e[n] − e[n−2]) + a1·y[n−1] + a2·y[n−2].
- R5: `cmd_vld` is high for exactly the one cycle after a cycle in which `smp_vld` is high and `clr` is low. It is low at all other times, and `cmd` is updated in that same cycle.
- R6: In a cycle without `smp_vld` and without `clr`, neither `cmd` nor either resonator state changes.
- R7: A command sum above 32767 is output as 32767, and a sum below −32768 is output as −32768.
- R8: `clr` takes priority over `smp_vld` in the same cycle: no `cmd_vld` follows, and the state is cleared.
- R9: With coefficients for a 400 Hz resonator with gain 100 and damping 0.05 at a 20 kHz sample rate, a steady 400 Hz error gives a command amplitude above 80 times the error amplitude. A 2 kHz error of the same amplitude gives a command amplitude below 10 times it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of output and resonator states |
| smp_vld | input | 1 | Sample strobe; advances the regulator by one step |
| i_act_ref | input | 16 | Active-current amplitude reference, Q2.14 |
| i_rea_ref | input | 16 | Reactive-current amplitude reference, Q2.14 |
| v_cos | input | 16 | In-phase unit grid signal, Q2.14 |
| v_sin | input | 16 | Quadrature unit grid signal, Q2.14 |
| i_meas | input | 16 | Measured grid current sample, Q2.14 |
| k_meas | input | 16 | Measurement scale, Q2.14 |
| k_prop | input | 20 | Proportional gain, Q4.16 |
| res_b0 | input | 20 | Resonator numerator coefficient (includes resonant gain), Q4.16 |
| res_a1 | input | 20 | Resonator first feedback coefficient, Q4.16 |
| res_a2 | input | 20 | Resonator second feedback coefficient, Q4.16 |
| cmd | output | 16 | Saturated modulation command |
| cmd_vld | output | 1 | Command update strobe |

## Verification
The bench builds the block with its default parameters: 16-bit Q2.14 data, 20-bit Q4.16 coefficients, a 32-bit accumulator, a 16-bit command and the scaled-measurement variant. With these values, exact integer expectations can be computed for every error path, including floor rounding of negative products and both saturation rails. The same defaults let the bench load the real 400 Hz tuning at 20 kHz, so the resonant peak and the off-frequency rejection can be seen within a few thousand cycles.

// File: rtl/pr_pkg.sv
package pr_pkg;
   // Selects how the measured current enters the error.
   typedef enum logic {
      MEAS_UNITY  = 1'b0,
      MEAS_SCALED = 1'b1
   } meas_mode_e;

   localparam int PR_DATA_W    = 16;
   localparam int PR_DATA_FRAC = 14;
   localparam int PR_COEF_W    = 20;
   localparam int PR_COEF_FRAC = 16;
   localparam int PR_ACC_W     = 32;
   localparam int PR_OUT_W     = 16;
endpackage

// File: rtl/pr_sat.sv
module pr_sat #(
   parameter int IN_W  = 52,
   parameter int OUT_W = 32
) (
   input  logic signed [IN_W-1:0]  din,
   output logic signed [OUT_W-1:0] dout
);
   generate
      if (IN_W > OUT_W) begin : g_clip
         localparam int HI_W = IN_W - OUT_W + 1;
         logic [HI_W-1:0] hi_bits;
         logic            ovf;
         assign hi_bits = din[IN_W-1:OUT_W-1];
         assign ovf     = !((&hi_bits) || !(|hi_bits));
         always_comb begin
            if (!ovf)
               dout = din[OUT_W-1:0];
            else if (din[IN_W-1])
               dout = {1'b1, {(OUT_W-1){1'b0}}};
            else
               dout = {1'b0, {(OUT_W-1){1'b1}}};
         end
      end else begin : g_pass
         assign dout = OUT_W'(din);
      end
   endgenerate
endmodule

// File: rtl/pr_err_gen.sv
module pr_err_gen
   import pr_pkg::*;
#(
   parameter int         DATA_W    = PR_DATA_W,
   parameter int         DATA_FRAC = PR_DATA_FRAC,
   parameter int         ACC_W     = PR_ACC_W,
   parameter meas_mode_e MEAS_MODE = MEAS_SCALED
) (
   input  logic signed [DATA_W-1:0] act_ref,
   input  logic signed [DATA_W-1:0] rea_ref,
   input  logic signed [DATA_W-1:0] cos_v,
   input  logic signed [DATA_W-1:0] sin_v,
   input  logic signed [DATA_W-1:0] meas,
   input  logic signed [DATA_W-1:0] k_meas,
   output logic signed [ACC_W-1:0]  err
);
   localparam int PROD_W = 2 * DATA_W;
   localparam int SUM_W  = PROD_W + 2;

   logic signed [PROD_W-1:0] p_act;
   logic signed [PROD_W-1:0] p_rea;
   logic signed [PROD_W-1:0] p_meas;
   logic signed [SUM_W-1:0]  sum;

   assign p_act = PROD_W'(act_ref) * PROD_W'(cos_v);
   assign p_rea = PROD_W'(rea_ref) * PROD_W'(sin_v);

   generate
      if (MEAS_MODE == MEAS_SCALED) begin : g_meas_scaled
         assign p_meas = PROD_W'(k_meas) * PROD_W'(meas);
      end else begin : g_meas_unity
         assign p_meas = PROD_W'(meas) <<< DATA_FRAC;
      end
   endgenerate

   assign sum = SUM_W'(p_act) + SUM_W'(p_rea) - SUM_W'(p_meas);
   assign err = ACC_W'(sum >>> DATA_FRAC);
endmodule

// File: rtl/pr_res.sv
module pr_res
   import pr_pkg::*;
#(
   parameter int ACC_W     = PR_ACC_W,
   parameter int COEF_W    = PR_COEF_W,
   parameter int COEF_FRAC = PR_COEF_FRAC
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic                     en,
   input  logic signed [ACC_W-1:0]  err,
   input  logic signed [COEF_W-1:0] b0,
   input  logic signed [COEF_W-1:0] a1,
   input  logic signed [COEF_W-1:0] a2,
   output logic signed [ACC_W-1:0]  y,
   output logic signed [ACC_W-1:0]  s1,
   output logic signed [ACC_W-1:0]  s2
);
   localparam int PW = ACC_W + COEF_W;

   logic signed [PW-1:0]    fwd;
   logic signed [PW-1:0]    y_pre;
   logic signed [PW-1:0]    s1_pre;
   logic signed [PW-1:0]    s2_pre;
   logic signed [ACC_W-1:0] s1_nxt;
   logic signed [ACC_W-1:0] s2_nxt;

   // Feed-forward term shared by the output and the second state.
   assign fwd   = (PW'(b0) * PW'(err)) >>> COEF_FRAC;
   assign y_pre = fwd + PW'(s1);

   pr_sat #(.IN_W(PW), .OUT_W(ACC_W)) u_sat_y (.din(y_pre), .dout(y));

   assign s1_pre = ((PW'(a1) * PW'(y)) >>> COEF_FRAC) + PW'(s2);
   assign s2_pre = ((PW'(a2) * PW'(y)) >>> COEF_FRAC) - fwd;

   pr_sat #(.IN_W(PW), .OUT_W(ACC_W)) u_sat_s1 (.din(s1_pre), .dout(s1_nxt));
   pr_sat #(.IN_W(PW), .OUT_W(ACC_W)) u_sat_s2 (.din(s2_pre), .dout(s2_nxt));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1 <= '0;
         s2 <= '0;
      end else if (clr) begin
         s1 <= '0;
         s2 <= '0;
      end else if (en) begin
         s1 <= s1_nxt;
         s2 <= s2_nxt;
      end
   end
endmodule

// File: rtl/pr_cur_reg.sv
module pr_cur_reg
   import pr_pkg::*;
#(
   parameter int         DATA_W    = PR_DATA_W,
   parameter int         DATA_FRAC = PR_DATA_FRAC,
   parameter int         COEF_W    = PR_COEF_W,
   parameter int         COEF_FRAC = PR_COEF_FRAC,
   parameter int         ACC_W     = PR_ACC_W,
   parameter int         OUT_W     = PR_OUT_W,
   parameter meas_mode_e MEAS_MODE = MEAS_SCALED
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic                     smp_vld,
   input  logic signed [DATA_W-1:0] i_act_ref,
   input  logic signed [DATA_W-1:0] i_rea_ref,
   input  logic signed [DATA_W-1:0] v_cos,
   input  logic signed [DATA_W-1:0] v_sin,
   input  logic signed [DATA_W-1:0] i_meas,
   input  logic signed [DATA_W-1:0] k_meas,
   input  logic signed [COEF_W-1:0] k_prop,
   input  logic signed [COEF_W-1:0] res_b0,
   input  logic signed [COEF_W-1:0] res_a1,
   input  logic signed [COEF_W-1:0] res_a2,
   output logic signed [OUT_W-1:0]  cmd,
   output logic                     cmd_vld
);
   localparam int PW = ACC_W + COEF_W;

   // Elaboration-time parameter checks.
   generate
      if (ACC_W < 2 * DATA_W) begin : g_bad_acc
         $error("pr_cur_reg: ACC_W must hold a full data product");
      end
      if (DATA_FRAC >= DATA_W) begin : g_bad_dfrac
         $error("pr_cur_reg: DATA_FRAC must be below DATA_W");
      end
      if (COEF_FRAC >= COEF_W) begin : g_bad_cfrac
         $error("pr_cur_reg: COEF_FRAC must be below COEF_W");
      end
      if (OUT_W > ACC_W) begin : g_bad_out
         $error("pr_cur_reg: OUT_W must not exceed ACC_W");
      end
   endgenerate

   logic signed [ACC_W-1:0] err;
   logic signed [ACC_W-1:0] res_y;
   logic signed [ACC_W-1:0] res_s1;
   logic signed [ACC_W-1:0] res_s2;
   logic signed [PW-1:0]    sum_pre;
   logic signed [OUT_W-1:0] cmd_nxt;
   logic                    step;

   assign step = smp_vld && !clr;

   pr_err_gen #(
      .DATA_W(DATA_W), .DATA_FRAC(DATA_FRAC), .ACC_W(ACC_W), .MEAS_MODE(MEAS_MODE)
   ) u_err (
      .act_ref(i_act_ref), .rea_ref(i_rea_ref), .cos_v(v_cos), .sin_v(v_sin),
      .meas(i_meas), .k_meas(k_meas), .err(err)
   );

   pr_res #(
      .ACC_W(ACC_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC)
   ) u_res (
      .clk(clk), .rst_n(rst_n), .clr(clr), .en(step), .err(err),
      .b0(res_b0), .a1(res_a1), .a2(res_a2),
      .y(res_y), .s1(res_s1), .s2(res_s2)
   );

   assign sum_pre = ((PW'(k_prop) * PW'(err)) >>> COEF_FRAC) + PW'(res_y);

   pr_sat #(.IN_W(PW), .OUT_W(OUT_W)) u_sat_cmd (.din(sum_pre), .dout(cmd_nxt));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd     <= '0;
         cmd_vld <= 1'b0;
      end else if (clr) begin
         cmd     <= '0;
         cmd_vld <= 1'b0;
      end else begin
         cmd_vld <= smp_vld;
         if (smp_vld)
            cmd <= cmd_nxt;
      end
   end
endmodule

// File: rtl/pr_cur_reg_chk.sv
module pr_cur_reg_chk #(
   parameter int ACC_W = 32,
   parameter int OUT_W = 16
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    clr,
   input logic                    smp_vld,
   input logic                    cmd_vld,
   input logic signed [OUT_W-1:0] cmd,
   input logic signed [ACC_W-1:0] st1,
   input logic signed [ACC_W-1:0] st2
);
   assert_strobe_vld_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && !clr) |=> cmd_vld);

   assert_idle_novld_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_vld |=> !cmd_vld);

   assert_clear_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!cmd_vld && cmd == '0));

   assert_clear_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (st1 == '0 && st2 == '0));

   assert_hold_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!smp_vld && !clr) |=> $stable(cmd));

   assert_hold_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!smp_vld && !clr) |=> ($stable(st1) && $stable(st2)));
endmodule

bind pr_cur_reg pr_cur_reg_chk #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .clr(clr), .smp_vld(smp_vld), .cmd_vld(cmd_vld),
   .cmd(cmd), .st1(res_s1), .st2(res_s2)
);

// File: tb/tb_pr_cur_reg.sv
module tb_pr_cur_reg;
   localparam int PERIOD = 10;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               clr = 1'b0;
   logic               smp_vld = 1'b0;
   logic signed [15:0] i_act_ref = '0;
   logic signed [15:0] i_rea_ref = '0;
   logic signed [15:0] v_cos = '0;
   logic signed [15:0] v_sin = '0;
   logic signed [15:0] i_meas = '0;
   logic signed [15:0] k_meas = '0;
   logic signed [19:0] k_prop = '0;
   logic signed [19:0] res_b0 = '0;
   logic signed [19:0] res_a1 = '0;
   logic signed [19:0] res_a2 = '0;
   logic signed [15:0] cmd;
   logic               cmd_vld;

   int     n_chk = 0;
   int     n_fail = 0;
   longint ms1 = 0;
   longint ms2 = 0;
   longint last_exp = 0;

   pr_cur_reg dut (
      .clk(clk), .rst_n(rst_n), .clr(clr), .smp_vld(smp_vld),
      .i_act_ref(i_act_ref), .i_rea_ref(i_rea_ref), .v_cos(v_cos), .v_sin(v_sin),
      .i_meas(i_meas), .k_meas(k_meas), .k_prop(k_prop),
      .res_b0(res_b0), .res_a1(res_a1), .res_a2(res_a2),
      .cmd(cmd), .cmd_vld(cmd_vld)
   );

   initial forever #(PERIOD / 2) clk = ~clk;

   function automatic longint satw(longint v, int w);
      longint hi = (longint'(1) <<< (w - 1)) - 1;
      longint lo = -hi - 1;
      if (v > hi) return hi;
      if (v < lo) return lo;
      return v;
   endfunction

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic set_coef(input longint kp, input longint b0, input longint a1,
                           input longint a2, input longint km);
      @(negedge clk);
      k_prop = 20'(kp); res_b0 = 20'(b0); res_a1 = 20'(a1); res_a2 = 20'(a2);
      k_meas = 16'(km);
   endtask

   // One accepted sample; the expected command follows R2, R3, R4 and R7.
   task automatic do_sample(input longint act, input longint rea, input longint c,
                            input longint s, input longint m, input bit chk, input string tag);
      longint e, fw, y, u;
      @(negedge clk);
      i_act_ref = 16'(act); i_rea_ref = 16'(rea); v_cos = 16'(c); v_sin = 16'(s);
      i_meas = 16'(m); smp_vld = 1'b1;
      e  = (act * c + rea * s - longint'(k_meas) * m) >>> 14;
      fw = (longint'(res_b0) * e) >>> 16;
      y  = satw(fw + ms1, 32);
      u  = satw(((longint'(k_prop) * e) >>> 16) + y, 16);
      ms1 = satw(((longint'(res_a1) * y) >>> 16) + ms2, 32);
      ms2 = satw(((longint'(res_a2) * y) >>> 16) - fw, 32);
      last_exp = u;
      @(negedge clk);
      smp_vld = 1'b0;
      if (chk) begin
         check(cmd_vld == 1'b1, {tag, " R5 vld"}, longint'(cmd_vld), 1);
         check(longint'(cmd) == u, tag, longint'(cmd), u);
      end
   endtask

   task automatic do_clear(input bit with_strobe);
      @(negedge clk);
      clr = 1'b1;
      smp_vld = with_strobe;
      i_act_ref = 16'sd12000; v_cos = 16'sd9000;
      @(negedge clk);
      clr = 1'b0; smp_vld = 1'b0;
      ms1 = 0; ms2 = 0;
      check(cmd_vld == 1'b0, "R8 no vld after clear", longint'(cmd_vld), 0);
      check(cmd == 16'sd0, "R1 cmd zero after clear", longint'(cmd), 0);
   endtask

   task automatic t_reset();
      check(cmd == 16'sd0, "R1 cmd after reset", longint'(cmd), 0);
      check(cmd_vld == 1'b0, "R1 vld after reset", longint'(cmd_vld), 0);
   endtask

   task automatic t_error_paths();
      set_coef(65536, 0, 0, 0, 16384);
      do_sample(8192, 0, 16384, 0, 0, 1, "R2 active path");
      check(last_exp == 8192, "R2 active value", last_exp, 8192);
      do_sample(0, 16384, 0, -8192, 0, 1, "R2 reactive path");
      do_sample(0, 0, 0, 0, 4096, 1, "R2 measured path");
      set_coef(65536, 0, 0, 0, 8192);
      do_sample(16384, 4096, 8192, 16384, 2048, 1, "R2 combined");
      check(last_exp == 11264, "R2 combined value", last_exp, 11264);
      do_sample(1, 0, -1, 0, 0, 1, "R2 floor of negative");
      check(last_exp == -1, "R2 floor value", last_exp, -1);
   endtask

   task automatic t_recurrence();
      do_clear(1'b0);
      set_coef(32768, 32768, 65536, -32768, 16384);
      do_sample(16384, 0, 4000, 0, 0, 1, "R3 first step");
      check(last_exp == 4000, "R3 first value", last_exp, 4000);
      do_sample(16384, 0, 0, 0, 0, 1, "R4 step 2");
      do_sample(16384, 0, -3000, 0, 0, 1, "R4 step 3");
      do_sample(0, 0, 0, 0, 1000, 1, "R4 step 4");
      do_sample(16384, 0, 2500, 0, 0, 1, "R4 step 5");
   endtask

   task automatic t_hold();
      logic signed [15:0] held;
      held = cmd;
      @(negedge clk);
      check(cmd_vld == 1'b0, "R5 vld drops", longint'(cmd_vld), 0);
      i_act_ref = 16'sd9999; v_cos = 16'sd7777;
      repeat (5) @(negedge clk);
      check(cmd == held, "R6 cmd held while idle", longint'(cmd), longint'(held));
      check(cmd_vld == 1'b0, "R6 no vld while idle", longint'(cmd_vld), 0);
      // zero error exposes the first state: it must be unchanged by idle cycles
      do_sample(0, 0, 0, 0, 0, 1, "R6 state held");
   endtask

   task automatic t_sat();
      do_clear(1'b0);
      set_coef(262144, 0, 0, 0, 16384);
      do_sample(32767, 0, 32767, 0, 0, 1, "R7 positive rail");
      check(longint'(cmd) == 32767, "R7 positive value", longint'(cmd), 32767);
      do_sample(32767, 0, -32768, 0, 0, 1, "R7 negative rail");
      check(longint'(cmd) == -32768, "R7 negative value", longint'(cmd), -32768);
   endtask

   task automatic t_clear();
      set_coef(32768, 32768, 65536, -32768, 16384);
      do_sample(16384, 0, 5000, 0, 0, 1, "R4 before clear");
      do_sample(16384, 0, 3000, 0, 0, 1, "R4 before clear 2");
      do_clear(1'b1);
      do_sample(0, 0, 0, 0, 0, 1, "R1 states zero after clear");
      check(longint'(cmd) == 0, "R8 cleared state value", longint'(cmd), 0);
   endtask

   task automatic t_resonance(input real f_hz, input bit expect_peak);
      real    w, ts, kd, wt, den;
      longint peak, amp;
      w  = 2.0 * 3.14159265358979 * 400.0;
      ts = 1.0 / 20000.0;
      kd = 0.1;
      wt = w * ts;
      den = 2.0 * kd * wt + wt * wt + 4.0;
      do_clear(1'b0);
      set_coef(65536,
               longint'($rtoi(100.0 * 2.0 * kd * wt / den * 65536.0 + 0.5)),
               longint'($rtoi((8.0 - 2.0 * wt * wt) / den * 65536.0 + 0.5)),
               longint'($rtoi((2.0 * kd * wt - wt * wt - 4.0) / den * 65536.0 - 0.5)),
               16384);
      amp  = 164;
      peak = 0;
      for (int n = 0; n < 1000; n++) begin
         longint c;
         c = longint'($rtoi(164.0 * $cos(2.0 * 3.14159265358979 * f_hz * ts * n)));
         do_sample(16384, 0, c, 0, 0, 0, "R9");
         if (n >= 800) begin
            if (longint'(cmd) > peak) peak = longint'(cmd);
            if (-longint'(cmd) > peak) peak = -longint'(cmd);
         end
      end
      if (expect_peak)
         check(peak > 80 * amp, "R9 gain at 400 Hz", peak, 80 * amp);
      else
         check(peak < 10 * amp, "R9 rejection at 2 kHz", peak, 10 * amp);
   endtask

   initial begin
      #(PERIOD * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_error_paths();
      t_recurrence();
      t_hold();
      t_sat();
      t_clear();
      t_resonance(400.0, 1'b1);
      t_resonance(2000.0, 1'b0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule